// File: doc/BRIEF.md
# Register Rename Map Table

This block sits right after instruction decode and gives temporary names to register results, one instruction per cycle, in program order. Each instruction brings two architectural source indices and an optional architectural destination. For each source the block reports whether the register is currently renamed, and if so which temporary tag will carry its value. A source that is not renamed is read from the architectural register itself. When the instruction writes a register, the block takes a fresh tag from a pool of free tags and records it as the newest name of that register. Later readers then see only that name, so write-after-read and write-after-write name conflicts go away.

The pool of tags is finite. Tags go back to the pool through a release port once every consumer of the value has received it. A release also drops the register's mapping, but only if that register still maps to the released tag. After that, readers use the architectural register again. When no tag is free, the block deasserts its ready output and accepts nothing.

Source and destination results are combinational in the cycle the instruction is presented. Map and pool updates take effect at the next rising clock edge.

Top module: `rename_map_table`

## Requirements
- R1: After synchronous reset, every architectural register reads as not renamed (mapped output 0), `in_ready` is 1 and all 8 tags are free.
- R2: An accepted instruction with `dst_en`=1 is given the lowest-numbered free tag on `dst_tag`, and that tag leaves the free pool at the next edge. An instruction is accepted when `in_valid` and `in_ready` are both 1.
- R3: Each source output shows mapped=1 with the register's current tag, or mapped=0 when the register has no mapping.
- R4: A later accepted write to the same architectural register replaces its mapping, so later readers see the newest tag.
- R5: An instruction that reads and writes the same register sees the old mapping on its source outputs.
- R6: When no tag is free, `in_ready` is 0 and a presented instruction changes neither the map nor the pool.
- R7: A released tag is free from the next cycle and can be allocated again.
- R8: A release clears a register's mapping only if that mapping still holds the released tag. Otherwise the mapping is kept.
- R9: An accepted instruction with `dst_en`=0 allocates no tag and changes no mapping.
- R10: If a rename writes register r in the same cycle as a release of r's old tag, r maps to the new tag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | A tag is free, so the instruction is accepted |
| src_a_reg | input | 4 | First source architectural register |
| src_b_reg | input | 4 | Second source architectural register |
| dst_en | input | 1 | Instruction writes a destination |
| dst_reg | input | 4 | Destination architectural register |
| src_a_mapped | output | 1 | First source is renamed |
| src_a_tag | output | 3 | Tag of first source when renamed |
| src_b_mapped | output | 1 | Second source is renamed |
| src_b_tag | output | 3 | Tag of second source when renamed |
| dst_tag | output | 3 | Tag allocated to the destination |
| rel_valid | input | 1 | Release a tag |
| rel_tag | input | 3 | Tag being released |

## Verification
Source translation, `dst_tag` and `in_ready` depend only on the current map, the pool and the present inputs. The bench therefore drives each instruction on a falling edge and compares these outputs one time unit later, in the same cycle. Map writes, release clears and pool changes become visible one rising edge later. The bench applies them to its model only after that edge, and observes them through the source outputs of the next instruction. Stalled and destination-less instructions are checked the same way, by reading the affected register on the following cycle.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
    parameter int ARCH_REGS = 16;
    parameter int PHYS_TAGS = 8;
    localparam int AW = $clog2(ARCH_REGS);
    localparam int TW = $clog2(PHYS_TAGS);

    typedef logic [AW-1:0] arch_t;
    typedef logic [TW-1:0] tag_t;
    typedef logic [PHYS_TAGS-1:0] pool_t;

    typedef struct packed {
        logic live;
        tag_t tag;
    } map_ent_t;

    // lowest set bit of the pool, zero when the pool is empty
    function automatic tag_t lowest_free(input pool_t pool);
        tag_t pick;
        pick = '0;
        for (int k = PHYS_TAGS - 1; k >= 0; k--) begin
            if (pool[k]) pick = tag_t'(k);
        end
        return pick;
    endfunction
endpackage

// File: rtl/rmt_free_pool.sv
module rmt_free_pool
    import rmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_en,
    input  logic  give_en,
    input  tag_t  give_tag,
    output logic  any_free,
    output tag_t  pick_tag,
    output pool_t pool_q
);
    pool_t take_mask, give_mask;

    assign any_free = |pool_q;
    assign pick_tag = lowest_free(pool_q);

    always_comb begin
        take_mask = '0;
        give_mask = '0;
        if (take_en) take_mask[pick_tag] = 1'b1;
        if (give_en) give_mask[give_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pool_q <= '1;
        else     pool_q <= (pool_q & ~take_mask) | give_mask;
    end

    // allocation only ever happens with a tag in the pool
    p_take_needs_free_r6: assert property (@(posedge clk) disable iff (rst)
        take_en |-> any_free);

    // an allocated tag has left the pool at the next edge
    p_taken_leaves_r2: assert property (@(posedge clk) disable iff (rst)
        take_en && !(give_en && give_tag == pick_tag) |=> !pool_q[$past(pick_tag)]);

    // a released tag is free at the next edge
    p_release_returns_r7: assert property (@(posedge clk) disable iff (rst)
        give_en |=> pool_q[$past(give_tag)]);
endmodule

// File: rtl/rmt_map.sv
module rmt_map
    import rmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  arch_t    wr_reg,
    input  tag_t     wr_tag,
    input  logic     clr_en,
    input  tag_t     clr_tag,
    input  arch_t    rd_a,
    input  arch_t    rd_b,
    input  pool_t    pool_i,
    output map_ent_t ent_a,
    output map_ent_t ent_b
);
    map_ent_t map_q [ARCH_REGS];

    assign ent_a = map_q[rd_a];
    assign ent_b = map_q[rd_b];

    for (genvar i = 0; i < ARCH_REGS; i++) begin : g_ent
        logic hit_wr, hit_clr;
        assign hit_wr  = wr_en && (wr_reg == arch_t'(i));
        assign hit_clr = clr_en && map_q[i].live && (map_q[i].tag == clr_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[i] <= '0;
            end else if (hit_wr) begin
                map_q[i] <= '{live: 1'b1, tag: wr_tag};
            end else if (hit_clr) begin
                map_q[i].live <= 1'b0;
            end
        end

        // a release of the held tag drops the entry unless it is rewritten
        p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
            clr_en && map_q[i].live && map_q[i].tag == clr_tag && !hit_wr
            |=> !map_q[i].live);

        // a release of another tag leaves the entry alone
        p_release_keeps_r8: assert property (@(posedge clk) disable iff (rst)
            clr_en && map_q[i].live && map_q[i].tag != clr_tag && !hit_wr
            |=> map_q[i].live && $stable(map_q[i].tag));

        // a tag held by the map is never in the free pool
        p_live_tag_busy_r7: assert property (@(posedge clk) disable iff (rst)
            map_q[i].live |-> !pool_i[map_q[i].tag]);
    end

    // a write is visible as the newest name one cycle later
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> map_q[$past(wr_reg)].live && map_q[$past(wr_reg)].tag == $past(wr_tag));
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
    import rmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [AW-1:0]     src_a_reg,
    input  logic [AW-1:0]     src_b_reg,
    input  logic              dst_en,
    input  logic [AW-1:0]     dst_reg,
    output logic              src_a_mapped,
    output logic [TW-1:0]     src_a_tag,
    output logic              src_b_mapped,
    output logic [TW-1:0]     src_b_tag,
    output logic [TW-1:0]     dst_tag,
    input  logic              rel_valid,
    input  logic [TW-1:0]     rel_tag
);
    logic     any_free, alloc_fire;
    tag_t     pick;
    pool_t    pool;
    map_ent_t ent_a, ent_b;

    assign in_ready   = any_free;
    assign alloc_fire = in_valid && any_free && dst_en;

    rmt_free_pool i_pool (
        .clk      (clk),
        .rst      (rst),
        .take_en  (alloc_fire),
        .give_en  (rel_valid),
        .give_tag (rel_tag),
        .any_free (any_free),
        .pick_tag (pick),
        .pool_q   (pool)
    );

    rmt_map i_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (alloc_fire),
        .wr_reg  (dst_reg),
        .wr_tag  (pick),
        .clr_en  (rel_valid),
        .clr_tag (rel_tag),
        .rd_a    (src_a_reg),
        .rd_b    (src_b_reg),
        .pool_i  (pool),
        .ent_a   (ent_a),
        .ent_b   (ent_b)
    );

    // sources come from the map as it stood before this instruction's write
    assign src_a_mapped = ent_a.live;
    assign src_a_tag    = ent_a.tag;
    assign src_b_mapped = ent_b.live;
    assign src_b_tag    = ent_b.tag;
    assign dst_tag      = pick;

    // a translated source never names a tag that sits in the free pool
    p_src_not_free_r3: assert property (@(posedge clk) disable iff (rst)
        src_a_mapped |-> !pool[src_a_tag]);

    // with the pool empty nothing is accepted and the pool stays empty
    p_stall_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !in_ready && !rel_valid |=> !in_ready);
endmodule

// File: tb/test_rename_map_table.sv
module test_rename_map_table;
    import rmt_pkg::*;

    logic clk = 0, rst = 1;
    logic in_valid = 0, dst_en = 0, rel_valid = 0;
    logic [AW-1:0] src_a_reg = 0, src_b_reg = 0, dst_reg = 0;
    logic [TW-1:0] rel_tag = 0;
    logic in_ready, src_a_mapped, src_b_mapped;
    logic [TW-1:0] src_a_tag, src_b_tag, dst_tag;

    int vectors = 0, errors = 0;
    bit m_live [ARCH_REGS];
    int m_tag  [ARCH_REGS];
    bit m_free [PHYS_TAGS];

    always #4 clk = ~clk;

    rename_map_table i_rename_map_table (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_a_reg(src_a_reg), .src_b_reg(src_b_reg), .dst_en(dst_en),
        .dst_reg(dst_reg), .src_a_mapped(src_a_mapped), .src_a_tag(src_a_tag),
        .src_b_mapped(src_b_mapped), .src_b_tag(src_b_tag), .dst_tag(dst_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag)
    );

    function automatic int exp_pick();
        for (int k = 0; k < PHYS_TAGS; k++) if (m_free[k]) return k;
        return -1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_src(string req, string nm, int r, bit mp, int tg);
        check(req, {nm, " mapped"}, mp, m_live[r]);
        if (m_live[r]) check(req, {nm, " tag"}, tg, m_tag[r]);
    endtask

    // one instruction: drive, check same-cycle outputs, clock, update model
    task automatic step(string req, bit v, int sa, int sb, bit dv, int d, bit rv, int rt);
        int pk;
        bit fire;
        @(negedge clk);
        in_valid = v; src_a_reg = AW'(sa); src_b_reg = AW'(sb);
        dst_en = dv; dst_reg = AW'(d); rel_valid = rv; rel_tag = TW'(rt);
        #1;
        pk = exp_pick();
        check(pk < 0 ? "R6" : req, "in_ready", in_ready, pk >= 0);
        check_src(req, "src_a", sa, src_a_mapped, src_a_tag);
        check_src(req, "src_b", sb, src_b_mapped, src_b_tag);
        fire = v && (pk >= 0) && dv;
        if (fire) check("R2", "dst_tag", dst_tag, pk);
        @(posedge clk);
        if (rv) begin
            m_free[rt] = 1;
            for (int i = 0; i < ARCH_REGS; i++)
                if (m_live[i] && m_tag[i] == rt && !(fire && d == i)) m_live[i] = 0;
        end
        if (fire) begin
            m_free[pk] = 0;
            m_live[d] = 1;
            m_tag[d] = pk;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int i = 0; i < ARCH_REGS; i++) begin m_live[i] = 0; m_tag[i] = 0; end
        for (int k = 0; k < PHYS_TAGS; k++) m_free[k] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: reset state, every register unmapped, ready, first tag is 0
        for (int r = 0; r < ARCH_REGS; r += 2) step("R1", 0, r, r + 1, 0, 0, 0, 0);
        // R2 / R3: first allocation, then read it back
        step("R2", 1, 0, 1, 1, 3, 0, 0);
        step("R3", 1, 3, 2, 0, 0, 0, 0);
        // R9: no destination means no allocation and no map change
        step("R9", 1, 4, 3, 0, 4, 0, 0);
        step("R9", 1, 4, 3, 1, 6, 0, 0);
        // R5: read and write the same register, old name on the source
        step("R5", 1, 3, 3, 1, 3, 0, 0);
        // R4: newest name seen by the next reader
        step("R4", 1, 3, 6, 0, 0, 0, 0);
        // R8: release a superseded tag of reg 3 (tag 0), mapping stays
        step("R8", 1, 3, 3, 0, 0, 1, 0);
        step("R8", 1, 3, 6, 0, 0, 0, 0);
        // R10: rewrite reg 3 while releasing its current tag (2)
        step("R10", 1, 3, 3, 1, 3, 1, 2);
        step("R10", 1, 3, 6, 0, 0, 0, 0);
        // R7: release the tag of reg 6 (1), unmapped, and reusable
        step("R7", 1, 6, 6, 0, 0, 1, 1);
        step("R7", 1, 6, 3, 1, 9, 0, 0);
        // R6: fill the pool, then try to rename while stalled
        for (int n = 0; n < PHYS_TAGS; n++) step("R6", 1, n, 9, 1, 10 + (n % 5), 0, 0);
        step("R6", 1, 15, 12, 1, 15, 0, 0);
        step("R6", 1, 15, 12, 0, 0, 0, 0);
        step("R7", 1, 10, 11, 0, 0, 1, 5);
        step("R7", 1, 15, 13, 1, 15, 0, 0);

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int rt;
            bit rv;
            rt = int'($urandom_range(PHYS_TAGS - 1));
            rv = ($urandom_range(99) < 40) && !m_free[rt];
            step("R3", $urandom_range(9) < 8, int'($urandom_range(ARCH_REGS - 1)),
                 int'($urandom_range(ARCH_REGS - 1)), $urandom_range(3) != 0,
                 int'($urandom_range(ARCH_REGS - 1)), rv, rt);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule